// File: doc/BRIEF.md
# USB Handshake Interrupt Filter

This block sits beside the transaction engine of a USB controller and decides, for each handshake that ends a transaction, whether an endpoint interrupt is raised. Every handshake arrives as a one-cycle event carrying its class (control, data IN or data OUT), its handshake code (ACK, NAK or NYET) and its endpoint number. Each class has its own 2-bit filter policy: pass every ACK and NAK, pass ACKs only, or pass ACKs plus only the first NAK after an ACK. For OUT traffic a NYET is treated as a successful handshake and counts like an ACK.

First-NAK tracking is kept per endpoint as one "armed" bit each. A successful handshake arms the endpoint, and any NAK disarms it. A USB bus reset re-arms every endpoint and restores the policy register. It leaves the output-signaling bits untouched.

A qualified event drives the interrupt pin. In level mode a sticky pending flag holds the pin active until software acknowledges it. In pulse mode each event produces a fixed-width pulse of about 60 ns, and a later event restarts that pulse. A polarity bit selects whether the pin is active high or active low. A small write port loads the policy register and the signaling register, and both are read back on dedicated outputs.

Top module: `hs_irq_filter`

## Requirements
- R1: After power-on reset the policy readback is 16'h0008 (control 00, IN 00, OUT 10), the signaling readback is 16'h0000 (level mode, active low), and `irq_pin` is 1 (inactive).
- R2: A write with `cfg_we`=1 and `cfg_sel`=0 loads the control policy from bit 7:6, the IN policy from bit 5:4 and the OUT policy from bit 3:2 of `cfg_wdata`. `mode_rd` returns these fields at the same positions, and every other bit of `mode_rd` always reads 0.
- R3: Policy 00 qualifies every ACK and every NAK of its class. For the OUT class it also qualifies every NYET. Handshake codes are: 00 = ACK, 01 = NAK, 10 = NYET, 11 = reserved. Class codes are: 00 = control, 01 = IN, 10 = OUT, 11 = reserved.
- R4: Policy 01 qualifies ACKs only, plus NYETs in the OUT class. It never qualifies a NAK.
- R5: A policy with bit 1 set (10 or 11) qualifies ACKs (and OUT NYETs), and qualifies a NAK only when that endpoint is armed. A qualified handshake (an ACK, or a NYET in the OUT class) arms its endpoint. Any NAK disarms its endpoint, whatever the policy. All endpoints are armed after reset, and each endpoint is tracked independently.
- R6: A NYET in the control or IN class, an event with reserved class 11 or reserved handshake 11, and an event presented while `bus_rst` is 1 are never qualified and do not change any endpoint's armed state.
- R7: In level mode (signaling bit 1 = 0) a qualified event sets a pending flag one clock later, and the flag holds the pin active until a cycle with `irq_ack`=1. If a qualified event and `irq_ack` fall in the same cycle, the flag stays set.
- R8: In pulse mode (signaling bit 1 = 1) the pin is active for exactly PULSE_CYC cycles after the clock edge that samples a qualified event. PULSE_CYC is ceil(CLK_MHZ*PULSE_NS/1000), which gives 4 with the defaults. A qualified event during a pulse restarts the full count.
- R9: Signaling bit 0 selects polarity: 0 means the pin is driven low when active, 1 means it is driven high when active.
- R10: A cycle with `bus_rst`=1 restores the policy readback to 16'h0008 and re-arms all endpoints. It leaves the signaling register, the pending flag and any running pulse unchanged. A policy write in the same cycle is overridden by the bus reset.
- R11: A write with `cfg_we`=1 and `cfg_sel`=1 loads polarity from `cfg_wdata` bit 0 and the pulse/level select from bit 1. `sig_rd` returns them at bits 1:0, and its other bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| bus_rst | input | 1 | USB bus reset indication, one cycle or longer |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 1 | Register select: 0 policy register, 1 signaling register |
| cfg_wdata | input | 16 | Register write data |
| mode_rd | output | 16 | Policy register readback |
| sig_rd | output | 16 | Signaling register readback |
| ev_valid | input | 1 | Handshake event strobe |
| ev_cat | input | 2 | Transaction class of the event |
| ev_hs | input | 2 | Handshake code of the event |
| ev_ep | input | 4 | Endpoint number of the event |
| irq_ack | input | 1 | Acknowledge that clears the pending flag |
| irq_pin | output | 1 | Interrupt output |

## Verification
The collision that matters most is a qualified handshake arriving in the same cycle as the software acknowledge of the pending flag. A lost interrupt shows up as the pin going inactive one cycle later. The bench provokes this collision in a directed case in level mode and then many more times from random stimulus, with a separate acknowledge probability. A bench reference model, in which a set takes priority over a clear, judges each cycle. The same model also judges a restarted pulse, where a second event lands inside a running pulse, and a bus reset that coincides with a NAK or a policy write.

// File: rtl/hs_irq_filter_pkg.sv
package hs_irq_filter_pkg;

   typedef enum logic [1:0] {
      CAT_CTRL = 2'b00,
      CAT_IN   = 2'b01,
      CAT_OUT  = 2'b10,
      CAT_RSVD = 2'b11
   } xfer_cat_e;

   typedef enum logic [1:0] {
      HS_ACK  = 2'b00,
      HS_NAK  = 2'b01,
      HS_NYET = 2'b10,
      HS_RSVD = 2'b11
   } hs_code_e;

   typedef struct packed {
      logic [1:0] ctrl;
      logic [1:0] din;
      logic [1:0] dout;
   } filt_modes_t;

   localparam logic [1:0] POLICY_ALL      = 2'b00;
   localparam logic [1:0] POLICY_ACK_ONLY = 2'b01;

   localparam filt_modes_t MODES_RESET = '{ctrl: 2'b00, din: 2'b00, dout: 2'b10};

   function automatic logic [15:0] pack_modes(input filt_modes_t m);
      return {8'h00, m.ctrl, m.din, m.dout, 2'b00};
   endfunction

endpackage

// File: rtl/hs_irq_cfg_regs.sv
module hs_irq_cfg_regs
   import hs_irq_filter_pkg::*;
#(
   parameter int REG_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             bus_rst,
   input  logic             wr_en,
   input  logic             wr_sel,
   input  logic [REG_W-1:0] wr_data,
   output filt_modes_t      modes,
   output logic             sig_pulse,
   output logic             sig_pol,
   output logic [REG_W-1:0] mode_rd,
   output logic [REG_W-1:0] sig_rd
);

   localparam int SIG_PAD = REG_W - 2;

   generate
      if (REG_W != 16) begin : g_bad_width
         $error("hs_irq_cfg_regs: REG_W must be 16");
      end
   endgenerate

   filt_modes_t modes_q;
   logic        pulse_q;
   logic        pol_q;

   logic unused_wr_bits;
   assign unused_wr_bits = ^{wr_data[REG_W-1:8], wr_data[1:0]};

   // policy register: restored by power-on and by USB bus reset
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         modes_q <= MODES_RESET;
      end else if (bus_rst) begin
         modes_q <= MODES_RESET;
      end else if (wr_en && !wr_sel) begin
         modes_q.ctrl <= wr_data[7:6];
         modes_q.din  <= wr_data[5:4];
         modes_q.dout <= wr_data[3:2];
      end
   end

   // signaling register: bus reset leaves it alone
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pulse_q <= 1'b0;
         pol_q   <= 1'b0;
      end else if (wr_en && wr_sel) begin
         pol_q   <= wr_data[0];
         pulse_q <= wr_data[1];
      end
   end

   assign modes     = modes_q;
   assign sig_pulse = pulse_q;
   assign sig_pol   = pol_q;
   assign mode_rd   = pack_modes(modes_q);
   assign sig_rd    = {{SIG_PAD{1'b0}}, pulse_q, pol_q};

   AST_BUS_RST_MODES: assert property (@(posedge clk) disable iff (!rst_n)
      bus_rst |=> (mode_rd == 16'h0008)) else $error("policy not restored"); // R10

   AST_SIG_KEPT_ON_BUS_RST: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rst && !wr_en) |=> $stable(sig_rd)) else $error("signaling changed"); // R10

   AST_MODE_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !wr_sel && !bus_rst) |=> (mode_rd[7:2] == $past(wr_data[7:2]))) else $error("policy write lost"); // R2

endmodule

// File: rtl/hs_irq_nak_tracker.sv
module hs_irq_nak_tracker #(
   parameter int N_EP = 16,
   parameter int EP_W = 4
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            bus_rst,
   input  logic [EP_W-1:0] ep,
   input  logic            arm_set,
   input  logic            arm_clr,
   output logic            armed_sel
);

   generate
      if (N_EP < 1 || (1 << EP_W) != N_EP) begin : g_bad_ep
         $error("hs_irq_nak_tracker: N_EP must equal 2**EP_W");
      end
   endgenerate

   logic [N_EP-1:0] armed_q;

   genvar gi;
   generate
      for (gi = 0; gi < N_EP; gi++) begin : g_ep
         logic hit_ep;
         assign hit_ep = (ep == EP_W'(gi));
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               armed_q[gi] <= 1'b1;
            end else if (bus_rst) begin
               armed_q[gi] <= 1'b1;
            end else if (hit_ep && arm_clr) begin
               armed_q[gi] <= 1'b0;
            end else if (hit_ep && arm_set) begin
               armed_q[gi] <= 1'b1;
            end
         end
      end
   endgenerate

   assign armed_sel = armed_q[ep];

   AST_NAK_DISARMS: assert property (@(posedge clk) disable iff (!rst_n)
      (arm_clr && !bus_rst) |=> !armed_q[$past(ep)]) else $error("NAK left endpoint armed"); // R5

   AST_BUS_RST_ARMS: assert property (@(posedge clk) disable iff (!rst_n)
      bus_rst |=> (&armed_q)) else $error("bus reset did not re-arm"); // R10

   AST_ONE_UPDATE: assert property (@(posedge clk) disable iff (!rst_n)
      !(arm_set && arm_clr)) else $error("arm set and clear together"); // R5

endmodule

// File: rtl/hs_irq_policy.sv
module hs_irq_policy
   import hs_irq_filter_pkg::*;
(
   input  logic        clk,
   input  logic        rst_n,
   input  filt_modes_t modes,
   input  logic        bus_rst,
   input  logic        ev_valid,
   input  logic [1:0]  ev_cat,
   input  logic [1:0]  ev_hs,
   input  logic        armed,
   output logic        hit,
   output logic        arm_set,
   output logic        arm_clr
);

   logic       ev_ok;
   logic       is_good;
   logic       is_nak;
   logic [1:0] policy;
   logic       nak_pass;

   always_comb begin
      unique case (ev_cat)
         CAT_CTRL: policy = modes.ctrl;
         CAT_IN:   policy = modes.din;
         CAT_OUT:  policy = modes.dout;
         default:  policy = POLICY_ACK_ONLY;
      endcase
   end

   assign ev_ok   = ev_valid && !bus_rst && (ev_cat != CAT_RSVD) && (ev_hs != HS_RSVD);
   assign is_good = (ev_hs == HS_ACK) || ((ev_hs == HS_NYET) && (ev_cat == CAT_OUT));
   assign is_nak  = (ev_hs == HS_NAK);

   always_comb begin
      if (policy == POLICY_ALL)           nak_pass = 1'b1;
      else if (policy == POLICY_ACK_ONLY) nak_pass = 1'b0;
      else                                nak_pass = armed;
   end

   assign hit     = ev_ok && (is_good || (is_nak && nak_pass));
   assign arm_set = ev_ok && is_good;
   assign arm_clr = ev_ok && is_nak;

   AST_ACK_ONLY_BLOCKS_NAK: assert property (@(posedge clk) disable iff (!rst_n)
      (ev_hs == HS_NAK && ev_cat == CAT_IN && modes.din == 2'b01) |-> !hit) else $error("NAK passed ACK-only policy"); // R4

   AST_NYET_NON_OUT: assert property (@(posedge clk) disable iff (!rst_n)
      (ev_hs == HS_NYET && ev_cat != CAT_OUT) |-> !(hit || arm_set || arm_clr)) else $error("NYET outside OUT acted"); // R6

   AST_ACK_ALWAYS: assert property (@(posedge clk) disable iff (!rst_n)
      (ev_valid && !bus_rst && ev_hs == HS_ACK && ev_cat != CAT_RSVD) |-> hit) else $error("ACK dropped"); // R3

endmodule

// File: rtl/hs_irq_signal.sv
module hs_irq_signal #(
   parameter int PULSE_CYC = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic hit,
   input  logic ack,
   input  logic pulse_sel,
   input  logic pol,
   output logic pin
);

   localparam int CNT_W = (PULSE_CYC < 2) ? 1 : $clog2(PULSE_CYC + 1);

   generate
      if (PULSE_CYC < 1) begin : g_bad_pulse
         $error("hs_irq_signal: PULSE_CYC must be at least 1");
      end
   endgenerate

   logic pending_q;
   logic pulse_act;

   // sticky flag: a new event wins over an acknowledge in the same cycle
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   pending_q <= 1'b0;
      else if (hit) pending_q <= 1'b1;
      else if (ack) pending_q <= 1'b0;
   end

   generate
      if (PULSE_CYC == 1) begin : g_pulse_reg
         logic pulse_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) pulse_q <= 1'b0;
            else        pulse_q <= hit;
         end
         assign pulse_act = pulse_q;
      end else begin : g_pulse_cnt
         logic [CNT_W-1:0] cnt_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)               cnt_q <= '0;
            else if (hit)             cnt_q <= CNT_W'(PULSE_CYC);
            else if (cnt_q != '0)     cnt_q <= cnt_q - 1'b1;
         end
         assign pulse_act = (cnt_q != '0);

         AST_PULSE_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
            hit |=> (cnt_q == CNT_W'(PULSE_CYC))) else $error("pulse not restarted"); // R8
      end
   endgenerate

   logic active;
   assign active = pulse_sel ? pulse_act : pending_q;
   assign pin    = pol ? active : !active;

   AST_PENDING_SET: assert property (@(posedge clk) disable iff (!rst_n)
      hit |=> pending_q) else $error("event lost against acknowledge"); // R7

   AST_PENDING_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      (ack && !hit) |=> !pending_q) else $error("acknowledge ignored"); // R7

   AST_PULSE_ON: assert property (@(posedge clk) disable iff (!rst_n)
      hit |=> pulse_act) else $error("no pulse after event"); // R8

endmodule

// File: rtl/hs_irq_filter.sv
module hs_irq_filter
   import hs_irq_filter_pkg::*;
#(
   parameter int N_EP     = 16,
   parameter int CLK_MHZ  = 60,
   parameter int PULSE_NS = 60
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      bus_rst,
   input  logic                      cfg_we,
   input  logic                      cfg_sel,
   input  logic [15:0]               cfg_wdata,
   output logic [15:0]               mode_rd,
   output logic [15:0]               sig_rd,
   input  logic                      ev_valid,
   input  logic [1:0]                ev_cat,
   input  logic [1:0]                ev_hs,
   input  logic [$clog2(N_EP)-1:0]   ev_ep,
   input  logic                      irq_ack,
   output logic                      irq_pin
);

   localparam int EP_W      = $clog2(N_EP);
   localparam int PULSE_RAW = (CLK_MHZ * PULSE_NS + 999) / 1000;
   localparam int PULSE_CYC = (PULSE_RAW < 1) ? 1 : PULSE_RAW;

   generate
      if (N_EP < 2) begin : g_bad_nep
         $error("hs_irq_filter: N_EP must be at least 2");
      end
      if (CLK_MHZ < 1 || PULSE_NS < 1) begin : g_bad_timing
         $error("hs_irq_filter: CLK_MHZ and PULSE_NS must be positive");
      end
   endgenerate

   filt_modes_t modes;
   logic        sig_pulse;
   logic        sig_pol;
   logic        armed;
   logic        hit;
   logic        arm_set;
   logic        arm_clr;

   hs_irq_cfg_regs #(.REG_W(16)) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_rst   (bus_rst),
      .wr_en     (cfg_we),
      .wr_sel    (cfg_sel),
      .wr_data   (cfg_wdata),
      .modes     (modes),
      .sig_pulse (sig_pulse),
      .sig_pol   (sig_pol),
      .mode_rd   (mode_rd),
      .sig_rd    (sig_rd)
   );

   hs_irq_nak_tracker #(.N_EP(N_EP), .EP_W(EP_W)) u_track (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_rst   (bus_rst),
      .ep        (ev_ep),
      .arm_set   (arm_set),
      .arm_clr   (arm_clr),
      .armed_sel (armed)
   );

   hs_irq_policy u_policy (
      .clk      (clk),
      .rst_n    (rst_n),
      .modes    (modes),
      .bus_rst  (bus_rst),
      .ev_valid (ev_valid),
      .ev_cat   (ev_cat),
      .ev_hs    (ev_hs),
      .armed    (armed),
      .hit      (hit),
      .arm_set  (arm_set),
      .arm_clr  (arm_clr)
   );

   hs_irq_signal #(.PULSE_CYC(PULSE_CYC)) u_sig (
      .clk       (clk),
      .rst_n     (rst_n),
      .hit       (hit),
      .ack       (irq_ack),
      .pulse_sel (sig_pulse),
      .pol       (sig_pol),
      .pin       (irq_pin)
   );

   AST_RSVD_BITS: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_rd[15:8] == 8'h00) && (mode_rd[1:0] == 2'b00) && (sig_rd[15:2] == 14'h0)) else $error("reserved bits set"); // R2

   AST_FIRST_NAK_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
      (hit && arm_clr && !bus_rst && ev_valid && ev_hs == 2'b01 && ev_cat == 2'b00 && modes.ctrl[1]
       ##1 (ev_valid && !bus_rst && ev_hs == 2'b01 && ev_cat == 2'b00 && ev_ep == $past(ev_ep) && modes.ctrl[1]))
      |-> !hit) else $error("second NAK passed"); // R5

endmodule

// File: tb/hs_irq_filter_test.sv
module hs_irq_filter_test;

   localparam int CLK_PERIOD = 10;
   localparam int PULSE      = 4;
   localparam int N_RANDOM   = 4000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_rst = 1'b0;
   logic        cfg_we = 1'b0;
   logic        cfg_sel = 1'b0;
   logic [15:0] cfg_wdata = '0;
   logic [15:0] mode_rd;
   logic [15:0] sig_rd;
   logic        ev_valid = 1'b0;
   logic [1:0]  ev_cat = '0;
   logic [1:0]  ev_hs = '0;
   logic [3:0]  ev_ep = '0;
   logic        irq_ack = 1'b0;
   logic        irq_pin;

   always #(CLK_PERIOD/2) clk = ~clk;

   hs_irq_filter uut (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_rst   (bus_rst),
      .cfg_we    (cfg_we),
      .cfg_sel   (cfg_sel),
      .cfg_wdata (cfg_wdata),
      .mode_rd   (mode_rd),
      .sig_rd    (sig_rd),
      .ev_valid  (ev_valid),
      .ev_cat    (ev_cat),
      .ev_hs     (ev_hs),
      .ev_ep     (ev_ep),
      .irq_ack   (irq_ack),
      .irq_pin   (irq_pin)
   );

   int n_vec = 0;
   int n_bad = 0;
   bit finished = 0;

   // reference model state
   logic [1:0]  m_ctrl, m_in, m_out;
   logic        m_pol, m_pls, m_pend;
   logic [15:0] m_arm;
   int          m_cnt;

   function automatic logic [1:0] pol_of(input logic [1:0] cat);
      case (cat)
         2'b00:   return m_ctrl;
         2'b01:   return m_in;
         default: return m_out;
      endcase
   endfunction

   function automatic bit ev_usable(input logic v, input logic [1:0] c, input logic [1:0] h, input logic br);
      return v && !br && (c != 2'b11) && (h != 2'b11);
   endfunction

   function automatic bit is_good(input logic [1:0] c, input logic [1:0] h);
      return (h == 2'b00) || (h == 2'b10 && c == 2'b10);
   endfunction

   function automatic bit exp_hit(input logic v, input logic [1:0] c, input logic [1:0] h,
                                  input logic [3:0] e, input logic br);
      logic [1:0] p;
      if (!ev_usable(v, c, h, br)) return 1'b0;
      if (is_good(c, h)) return 1'b1;
      if (h != 2'b01) return 1'b0;
      p = pol_of(c);
      if (p == 2'b00) return 1'b1;
      if (p == 2'b01) return 1'b0;
      return m_arm[e];
   endfunction

   function automatic logic exp_pin();
      logic act;
      act = m_pls ? (m_cnt != 0) : m_pend;
      return m_pol ? act : ~act;
   endfunction

   function automatic logic [15:0] exp_mode();
      return {8'h00, m_ctrl, m_in, m_out, 2'b00};
   endfunction

   task automatic model_reset();
      m_ctrl = 2'b00; m_in = 2'b00; m_out = 2'b10;
      m_pol = 1'b0; m_pls = 1'b0; m_pend = 1'b0;
      m_arm = '1; m_cnt = 0;
   endtask

   task automatic model_edge();
      bit h;
      h = exp_hit(ev_valid, ev_cat, ev_hs, ev_ep, bus_rst);
      if (bus_rst) m_arm = '1;
      else if (ev_usable(ev_valid, ev_cat, ev_hs, bus_rst)) begin
         if (ev_hs == 2'b01)              m_arm[ev_ep] = 1'b0;
         else if (is_good(ev_cat, ev_hs)) m_arm[ev_ep] = 1'b1;
      end
      if (bus_rst) begin
         m_ctrl = 2'b00; m_in = 2'b00; m_out = 2'b10;
      end else if (cfg_we && !cfg_sel) begin
         m_ctrl = cfg_wdata[7:6]; m_in = cfg_wdata[5:4]; m_out = cfg_wdata[3:2];
      end
      if (cfg_we && cfg_sel) begin
         m_pol = cfg_wdata[0]; m_pls = cfg_wdata[1];
      end
      if (h)            m_pend = 1'b1;
      else if (irq_ack) m_pend = 1'b0;
      if (h)                m_cnt = PULSE;
      else if (m_cnt > 0)   m_cnt = m_cnt - 1;
   endtask

   task automatic compare(input string tag);
      n_vec++;
      if (irq_pin !== exp_pin() || mode_rd !== exp_mode() || sig_rd !== {14'h0, m_pls, m_pol}) begin
         n_bad++;
         $display("FAIL %s: pin=%b mode=%h sig=%h expected pin=%b mode=%h sig=%h",
                  tag, irq_pin, mode_rd, sig_rd, exp_pin(), exp_mode(), {14'h0, m_pls, m_pol});
      end
   endtask

   // called at a falling edge with inputs already driven
   task automatic step(input string tag);
      @(posedge clk);
      model_edge();
      @(negedge clk);
      compare(tag);
      ev_valid = 1'b0; cfg_we = 1'b0; irq_ack = 1'b0; bus_rst = 1'b0;
   endtask

   task automatic ev(input logic [1:0] c, input logic [1:0] h, input logic [3:0] e, input string tag);
      ev_valid = 1'b1; ev_cat = c; ev_hs = h; ev_ep = e;
      step(tag);
   endtask

   task automatic wr(input logic sel, input logic [15:0] d, input string tag);
      cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
      step(tag);
   endtask

   task automatic ackc(input string tag);
      irq_ack = 1'b1;
      step(tag);
   endtask

   task automatic idle(input string tag);
      step(tag);
   endtask

   task automatic summary();
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
   endtask

   initial begin
      model_reset();
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      compare("R1 reset state");

      // R2 / R11 register access
      wr(1'b0, 16'hFFFF, "R2 reserved bits of policy");
      wr(1'b0, 16'h0000, "R2 policy cleared");
      wr(1'b0, 16'h0098, "R2 field positions");
      wr(1'b1, 16'hFFFE, "R11 signaling write");
      wr(1'b1, 16'h0000, "R11 signaling back to level low");

      // R3 policy 00 on all classes
      wr(1'b0, 16'h0000, "R3 setup");
      ev(2'b00, 2'b00, 4'd1, "R3 control ACK");
      ackc("R7 acknowledge clears");
      ev(2'b01, 2'b01, 4'd1, "R3 IN NAK");
      ev(2'b01, 2'b01, 4'd1, "R3 IN NAK repeated");
      ackc("R7 acknowledge clears");
      ev(2'b10, 2'b10, 4'd2, "R3 OUT NYET");
      ackc("R7 acknowledge clears");

      // R4 policy 01
      wr(1'b0, 16'h0054, "R4 setup");
      ev(2'b00, 2'b01, 4'd3, "R4 control NAK blocked");
      ev(2'b10, 2'b01, 4'd3, "R4 OUT NAK blocked");
      ev(2'b10, 2'b10, 4'd3, "R4 OUT NYET passes");
      ackc("R4 clear");

      // R5 first NAK on policy 10
      wr(1'b0, 16'h00A8, "R5 setup");
      ev(2'b01, 2'b01, 4'd5, "R5 armed after reset");
      ackc("R5 clear");
      ev(2'b01, 2'b01, 4'd5, "R5 second NAK blocked");
      ev(2'b01, 2'b01, 4'd6, "R5 other endpoint independent");
      ackc("R5 clear");
      ev(2'b01, 2'b00, 4'd5, "R5 ACK re-arms");
      ackc("R5 clear");
      ev(2'b01, 2'b01, 4'd5, "R5 first NAK after ACK");
      ackc("R5 clear");
      ev(2'b10, 2'b10, 4'd5, "R5 OUT NYET arms");
      ackc("R5 clear");
      ev(2'b10, 2'b01, 4'd5, "R5 NAK after NYET");
      ackc("R5 clear");

      // R6 ignored events
      ev(2'b00, 2'b10, 4'd5, "R6 control NYET ignored");
      ev(2'b01, 2'b01, 4'd5, "R6 endpoint still disarmed");
      ev(2'b11, 2'b00, 4'd7, "R6 reserved class ignored");
      ev(2'b00, 2'b11, 4'd7, "R6 reserved code ignored");

      // R7 collision of event and acknowledge
      ev(2'b00, 2'b00, 4'd0, "R7 set");
      ev_valid = 1'b1; ev_cat = 2'b00; ev_hs = 2'b00; ev_ep = 4'd0; irq_ack = 1'b1;
      step("R7 event wins over acknowledge");
      idle("R7 still pending");
      ackc("R7 cleared");

      // R9 polarity, R8 pulse
      wr(1'b1, 16'h0001, "R9 active high level");
      ev(2'b00, 2'b00, 4'd0, "R9 high when active");
      ackc("R9 low when inactive");
      wr(1'b1, 16'h0002, "R8 pulse mode active low");
      ev(2'b00, 2'b00, 4'd0, "R8 pulse cycle 1");
      idle("R8 pulse cycle 2");
      ev(2'b00, 2'b00, 4'd0, "R8 pulse restarted");
      for (int i = 0; i < PULSE + 2; i++) idle("R8 pulse tail");
      wr(1'b1, 16'h0000, "R8 back to level shows pending");
      ackc("R8 clear");

      // R10 bus reset
      wr(1'b0, 16'h00FC, "R10 setup");
      ev(2'b10, 2'b01, 4'd9, "R10 disarm endpoint");
      ackc("R10 clear");
      wr(1'b1, 16'h0001, "R10 signaling set");
      bus_rst = 1'b1; cfg_we = 1'b1; cfg_sel = 1'b0; cfg_wdata = 16'h0054;
      ev_valid = 1'b1; ev_cat = 2'b00; ev_hs = 2'b00; ev_ep = 4'd9;
      step("R10 bus reset overrides write and event");
      ev(2'b10, 2'b01, 4'd9, "R10 endpoint re-armed, OUT policy 10");
      ackc("R10 clear");

      // random phase
      void'($urandom(32'd20240611));
      for (int k = 0; k < N_RANDOM; k++) begin
         ev_valid  = ($urandom_range(1, 0) == 1);
         ev_cat    = 2'($urandom_range(3, 0));
         ev_hs     = 2'($urandom_range(3, 0));
         ev_ep     = 4'($urandom_range(3, 0));
         irq_ack   = ($urandom_range(3, 0) == 0);
         bus_rst   = ($urandom_range(63, 0) == 0);
         cfg_we    = ($urandom_range(15, 0) == 0);
         cfg_sel   = ($urandom_range(1, 0) == 1);
         cfg_wdata = 16'($urandom);
         step("R3/R4/R5/R7/R8 random");
      end

      finished = 1;
      summary();
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 200000);
      if (!finished) begin
         n_bad++;
         $display("FAIL watchdog: run did not complete, expected completion");
         summary();
         $finish;
      end
   end

endmodule